// File: doc/BRIEF.md
# Four-Lane Complex Upconverting Interpolator

This block is the final digital stage of a wideband transmitter. Every clock it takes one complex baseband sample carrying the whole multichannel signal. It moves that signal in frequency by multiplying it with a complex exponential from a small phase-indexed oscillator table. It then raises the sample rate by four through a polyphase complex bandpass filter and keeps only the real part of the analytic result. Each clock it emits four real samples, which an external multiplexing converter serialises into consecutive samples at four times the clock rate.

The frequency shift is applied at the low rate, before any rate increase. A tuning input sets the per-clock phase step, so the band can be moved without a reset. When no input sample is offered, the block feeds a zero in its place and keeps producing output. The filter taps arrive on static coefficient buses. A fixed gain of four makes up for the energy lost to zero insertion. Every arithmetic result is rounded half-up and saturated to the data width.

Top module: `rf_interp_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every output lane reads 0.
- R2: The mixed sample is y[n] = sat16(floor((x[n]·w[n] + 2^14) / 2^15)), computed separately for the real and imaginary parts. Here w[n] = C[q] + j·S[q], with C[q] = round(32767·cos(2πq/64)) and S[q] = round(32767·sin(2πq/64)), rounding half away from zero. The table index q is the 6-bit phase, which is 0 at the first clock edge after reset and grows by `tune_step` (mod 64) on every clock edge.
- R3: A clock edge with `in_valid` low inserts y = 0 into the filter, and the phase still advances.
- R4: The outputs produced after clock edge m come from the mixed samples taken at edges m-2 and earlier. Lane p gives Re(Σ_k h[4k+p]·y[m-2-k]) for k = 0..10.
- R5: The lane value is floor((4·acc + 2^14) / 2^15), which is the same as rounding the accumulator half-up at bit 13. Here acc is the full-precision sum and h is in Q15.
- R6: Lane values beyond the 16-bit range saturate to 32767 or -32768.
- R7: Lane 0 (`rf_out[15:0]`) holds the earliest of the four RF samples and lane 3 (`rf_out[63:48]`) the latest. Tap i of the prototype sits at bits [16i+15:16i] of the coefficient buses.
- R8: A change of `tune_step` takes effect from the current phase, with no discontinuity or restart.
- R9: The imaginary parts of coefficient and signal enter the output as −Im(h)·Im(y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the baseband rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_re`/`in_im` as a sample; low inserts a zero |
| in_re | input | 16 | Baseband sample, real part, signed |
| in_im | input | 16 | Baseband sample, imaginary part, signed |
| tune_step | input | 6 | Phase increment per clock into the 64-entry oscillator table |
| coef_re | input | 704 | Real parts of the 44 prototype taps, Q15 |
| coef_im | input | 704 | Imaginary parts of the 44 prototype taps, Q15 |
| rf_out | output | 64 | Four real RF samples, lane 0 earliest |

## Verification
The first test sets tap 0 to 0.25 and tap 1 to −0.25j, which makes lanes 0 and 1 show the rotated sample's real and imaginary parts exactly. A constant input under several phase steps then separates errors in the oscillator table, in the rotation sign and in phase tracking. A lone impulse through distinct per-tap gains shows the lane order and the tap-to-delay mapping. Gapped valid patterns show that zeros are inserted while the phase keeps moving. Inputs just either side of a rounding half-step, and full-scale inputs through full-scale taps, separate round-half-up from truncation and saturation from wrap. A long pseudo-random run with random complex taps exercises every product path together.

// File: rtl/fx_pkg.sv
package fx_pkg;

  // Quantised oscillator table entry: round(amp * cos|sin(2*pi*k/n)),
  // halves rounded away from zero.
  function automatic int trig_q(input int k, input int n, input int amp,
                                input bit sine);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(n);
    v   = sine ? real'(amp) * $sin(ang) : real'(amp) * $cos(ang);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/cplx_mixer.sv
module cplx_mixer #(
  parameter int DW   = 16,
  parameter int PH_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [PH_W-1:0]      tune_step,
  output logic signed [DW-1:0] mix_re,
  output logic signed [DW-1:0] mix_im
);
  localparam int LUT_N = 2 ** PH_W;
  localparam int AMP   = (2 ** (DW - 1)) - 1;
  localparam int PW    = 2 * DW;
  localparam int SW    = PW + 2;
  localparam int FRAC  = DW - 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] SMAX = SW'(AMP);
  localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);

  logic signed [DW-1:0] cos_tab [LUT_N];
  logic signed [DW-1:0] sin_tab [LUT_N];

  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam int CV = fx_pkg::trig_q(k, LUT_N, AMP, 1'b0);
    localparam int SV = fx_pkg::trig_q(k, LUT_N, AMP, 1'b1);
    assign cos_tab[k] = DW'(CV);
    assign sin_tab[k] = DW'(SV);
  end

  logic [PH_W-1:0]      phase;
  logic signed [DW-1:0] xr, xi, wc, ws;
  logic signed [PW-1:0] p_rc, p_is, p_rs, p_ic;
  logic signed [SW-1:0] sum_r, sum_i, rnd_r, rnd_i;
  logic signed [DW-1:0] sat_r, sat_i;

  always_comb begin
    xr    = in_valid ? in_re : '0;
    xi    = in_valid ? in_im : '0;
    wc    = cos_tab[phase];
    ws    = sin_tab[phase];
    p_rc  = xr * wc;
    p_is  = xi * ws;
    p_rs  = xr * ws;
    p_ic  = xi * wc;
    sum_r = SW'(p_rc) - SW'(p_is);
    sum_i = SW'(p_rs) + SW'(p_ic);
    rnd_r = (sum_r + HALF) >>> FRAC;
    rnd_i = (sum_i + HALF) >>> FRAC;
    if (rnd_r > SMAX)      sat_r = DW'(SMAX);
    else if (rnd_r < SMIN) sat_r = DW'(SMIN);
    else                   sat_r = DW'(rnd_r);
    if (rnd_i > SMAX)      sat_i = DW'(SMAX);
    else if (rnd_i < SMIN) sat_i = DW'(SMIN);
    else                   sat_i = DW'(rnd_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      mix_re <= '0;
      mix_im <= '0;
    end else begin
      phase  <= phase + tune_step;
      mix_re <= sat_r;
      mix_im <= sat_i;
    end
  end

  // R3: an empty slot becomes a zero sample one edge later
  p_gap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (mix_re == '0 && mix_im == '0));

  // R8: phase moves by the step seen at the previous edge
  p_phase_adv_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == PH_W'($past(phase) + $past(tune_step)));

endmodule

// File: rtl/tap_line.sv
module tap_line #(
  parameter int DW = 16,
  parameter int NT = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] din_re,
  input  logic signed [DW-1:0] din_im,
  output logic [NT*DW-1:0]     taps_re,
  output logic [NT*DW-1:0]     taps_im
);
  logic signed [DW-1:0] sr_re [NT];
  logic signed [DW-1:0] sr_im [NT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NT; k++) begin
        sr_re[k] <= '0;
        sr_im[k] <= '0;
      end
    end else begin
      sr_re[0] <= din_re;
      sr_im[0] <= din_im;
      for (int k = 1; k < NT; k++) begin
        sr_re[k] <= sr_re[k-1];
        sr_im[k] <= sr_im[k-1];
      end
    end
  end

  for (genvar k = 0; k < NT; k++) begin : g_flat
    assign taps_re[k*DW +: DW] = sr_re[k];
    assign taps_im[k*DW +: DW] = sr_im[k];
  end

  if (NT > 1) begin : g_chk
    // R4: each sample ages by exactly one position per clock
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (sr_re[1] == $past(sr_re[0]) && sr_im[1] == $past(sr_im[0])));
  end

endmodule

// File: rtl/branch_mac.sv
module branch_mac #(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int NT      = 11,
  parameter int GAIN_SH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NT*DW-1:0]     taps_re,
  input  logic [NT*DW-1:0]     taps_im,
  input  logic [NT*CW-1:0]     h_re,
  input  logic [NT*CW-1:0]     h_im,
  output logic signed [DW-1:0] lane_q
);
  localparam int PW    = DW + CW;
  localparam int ACC_W = PW + $clog2(2 * NT) + 1;
  localparam int SH    = CW - 1 - GAIN_SH;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = -SMAX - ACC_W'(1);

  logic signed [ACC_W-1:0] acc, rnd;
  logic signed [DW-1:0]    lane_d;

  always_comb begin
    logic signed [DW-1:0] yr, yi;
    logic signed [CW-1:0] hr, hi;
    logic signed [PW-1:0] pr, pi;
    acc = '0;
    for (int k = 0; k < NT; k++) begin
      yr  = taps_re[k*DW +: DW];
      yi  = taps_im[k*DW +: DW];
      hr  = h_re[k*CW +: CW];
      hi  = h_im[k*CW +: CW];
      pr  = hr * yr;
      pi  = hi * yi;
      acc = acc + ACC_W'(pr) - ACC_W'(pi);
    end
    rnd = (acc + HALF) >>> SH;
    if (rnd > SMAX)      lane_d = DW'(SMAX);
    else if (rnd < SMIN) lane_d = DW'(SMIN);
    else                 lane_d = DW'(rnd);
  end

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else     lane_q <= lane_d;
  end

endmodule

// File: rtl/rf_interp_tx.sv
module rf_interp_tx #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int LANES = 4,
  parameter int TAPS  = 44,
  parameter int PH_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  in_re,
  input  logic signed [DW-1:0]  in_im,
  input  logic [PH_W-1:0]       tune_step,
  input  logic [TAPS*CW-1:0]    coef_re,
  input  logic [TAPS*CW-1:0]    coef_im,
  output logic [LANES*DW-1:0]   rf_out
);
  localparam int BR = TAPS / LANES;

  logic signed [DW-1:0] mix_re, mix_im;
  logic [BR*DW-1:0]     taps_re, taps_im;
  logic [BR*CW-1:0]     lane_hr [LANES];
  logic [BR*CW-1:0]     lane_hi [LANES];

  cplx_mixer #(.DW(DW), .PH_W(PH_W)) u_mix (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .tune_step(tune_step), .mix_re(mix_re), .mix_im(mix_im)
  );

  tap_line #(.DW(DW), .NT(BR)) u_line (
    .clk(clk), .rst(rst), .din_re(mix_re), .din_im(mix_im),
    .taps_re(taps_re), .taps_im(taps_im)
  );

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    for (genvar k = 0; k < BR; k++) begin : g_pick
      assign lane_hr[p][k*CW +: CW] = coef_re[(k*LANES + p)*CW +: CW];
      assign lane_hi[p][k*CW +: CW] = coef_im[(k*LANES + p)*CW +: CW];
    end
    logic signed [DW-1:0] lane_q;
    branch_mac #(.DW(DW), .CW(CW), .NT(BR), .GAIN_SH(2)) u_mac (
      .clk(clk), .rst(rst), .taps_re(taps_re), .taps_im(taps_im),
      .h_re(lane_hr[p]), .h_im(lane_hi[p]), .lane_q(lane_q)
    );
    assign rf_out[p*DW +: DW] = lane_q;
  end

  logic line_quiet;
  assign line_quiet = (taps_re == '0) && (taps_im == '0);

  // R1: outputs are cleared by reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> rf_out == '0);

  // R4: an all-zero delay line yields all-zero lanes next edge
  p_quiet_out_r4: assert property (@(posedge clk) disable iff (rst)
    line_quiet |=> rf_out == '0);

endmodule

// File: tb/rf_interp_tx_tb.sv
module rf_interp_tx_tb;
  localparam int DW = 16, CW = 16, LANES = 4, TAPS = 44, PH_W = 6;
  localparam int BR = TAPS / LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic [PH_W-1:0] tune_step = '0;
  logic [TAPS*CW-1:0] coef_re, coef_im;
  logic [LANES*DW-1:0] rf_out;

  int cr [TAPS];
  int ci [TAPS];
  int checks = 0, errors = 0;

  longint yreg_r, yreg_i, ph_m;
  longint dlr [BR];
  longint dli [BR];
  longint out_m [LANES];

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < TAPS; i++) begin
      coef_re[i*CW +: CW] = CW'(cr[i]);
      coef_im[i*CW +: CW] = CW'(ci[i]);
    end
  end

  rf_interp_tx #(.DW(DW), .CW(CW), .LANES(LANES), .TAPS(TAPS), .PH_W(PH_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .tune_step(tune_step), .coef_re(coef_re), .coef_im(coef_im), .rf_out(rf_out)
  );

  function automatic longint tq(input int k, input bit sine);
    real ang, v;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / 64.0;
    v = sine ? 32767.0 * $sin(ang) : 32767.0 * $cos(ang);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    else          return longint'($rtoi(v - 0.5));
  endfunction

  function automatic longint rs(input longint v, input int sh);
    longint r;
    r = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_zero();
    yreg_r = 0; yreg_i = 0; ph_m = 0;
    for (int k = 0; k < BR; k++) begin dlr[k] = 0; dli[k] = 0; end
    for (int p = 0; p < LANES; p++) out_m[p] = 0;
  endtask

  // one clock: the expected state follows R2..R6 at each edge
  task automatic cyc();
    longint xr, xi, c, s, acc;
    @(posedge clk);
    if (rst) model_zero();
    else begin
      for (int p = 0; p < LANES; p++) begin
        acc = 0;
        for (int k = 0; k < BR; k++)
          acc += longint'(cr[k*LANES+p]) * dlr[k] - longint'(ci[k*LANES+p]) * dli[k];
        out_m[p] = rs(acc, 13);
      end
      for (int k = BR-1; k > 0; k--) begin dlr[k] = dlr[k-1]; dli[k] = dli[k-1]; end
      dlr[0] = yreg_r; dli[0] = yreg_i;
      xr = in_valid ? longint'(in_re) : 0;
      xi = in_valid ? longint'(in_im) : 0;
      c = tq(int'(ph_m), 1'b0);
      s = tq(int'(ph_m), 1'b1);
      yreg_r = rs(xr * c - xi * s, 15);
      yreg_i = rs(xr * s + xi * c, 15);
      ph_m = (ph_m + longint'(tune_step)) % 64;
    end
    @(negedge clk);
  endtask

  task automatic check_lanes(input string req);
    longint act;
    for (int p = 0; p < LANES; p++) begin
      act = longint'($signed(rf_out[p*DW +: DW]));
      checks++;
      if (act != out_m[p]) begin
        errors++;
        $display("FAIL %s lane %0d actual %0d expected %0d", req, p, act, out_m[p]);
      end
    end
  endtask

  task automatic clear_coefs();
    for (int i = 0; i < TAPS; i++) begin cr[i] = 0; ci[i] = 0; end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) begin cyc(); check_lanes("R1"); end
    rst = 1'b0;
    cyc(); check_lanes("R1");
  endtask

  // R2 and R9: lane0 = Re(y), lane1 = Im(y) via taps 0.25 and -0.25j
  task automatic t_rotate(input int step);
    clear_coefs(); cr[0] = 8192; ci[1] = -8192;
    do_reset();
    tune_step = PH_W'(step);
    for (int n = 0; n < 40; n++) begin
      in_valid = 1'b1; in_re = 16'sd12000; in_im = -16'sd5000;
      cyc(); check_lanes("R2");
    end
  endtask

  // R3: gaps insert zeros while the phase still advances
  task automatic t_gaps();
    clear_coefs(); cr[0] = 8192; ci[1] = -8192; cr[4] = 4000; ci[6] = 3000;
    do_reset();
    tune_step = 6'd7;
    for (int n = 0; n < 48; n++) begin
      in_valid = (n % 3) != 1; in_re = 16'sd20000; in_im = 16'sd9000;
      cyc(); check_lanes("R3");
    end
  endtask

  // R4 and R7: impulse through distinct taps shows lane order and tap map
  task automatic t_impulse();
    clear_coefs();
    for (int i = 0; i < TAPS; i++) cr[i] = (i + 1) * 60;
    do_reset();
    tune_step = '0;
    in_valid = 1'b1; in_re = 16'sd16384; in_im = '0;
    cyc(); check_lanes("R7");
    in_valid = 1'b0;
    for (int n = 0; n < 16; n++) begin cyc(); check_lanes("R4"); end
  endtask

  // R5: values around a rounding half-step
  task automatic t_round();
    int vals [8] = '{4096, 4095, -4096, -4097, 12288, 12287, -12288, -12289};
    clear_coefs(); cr[0] = 1; ci[1] = 1;
    do_reset();
    tune_step = '0;
    foreach (vals[i]) begin
      in_valid = 1'b1; in_re = DW'(vals[i]); in_im = DW'(-vals[i]);
      cyc(); check_lanes("R5");
    end
    in_valid = 1'b0;
    repeat (3) begin cyc(); check_lanes("R5"); end
  endtask

  // R6: full-scale input through full-scale taps saturates both ways
  task automatic t_saturate();
    clear_coefs();
    for (int i = 0; i < TAPS; i++) cr[i] = 32767;
    do_reset();
    tune_step = '0;
    for (int n = 0; n < 14; n++) begin
      in_valid = 1'b1; in_re = 16'sd32767; in_im = '0;
      cyc(); check_lanes("R6");
    end
    for (int n = 0; n < 14; n++) begin
      in_valid = 1'b1; in_re = -16'sd32768; in_im = '0;
      cyc(); check_lanes("R6");
    end
  endtask

  // R8: retune mid-stream, phase continues from where it was
  task automatic t_retune();
    clear_coefs(); cr[0] = 8192; ci[1] = -8192;
    do_reset();
    tune_step = 6'd3;
    for (int n = 0; n < 60; n++) begin
      if (n == 20) tune_step = 6'd61;
      if (n == 40) tune_step = 6'd16;
      in_valid = 1'b1; in_re = 16'sd15000; in_im = 16'sd15000;
      cyc(); check_lanes("R8");
    end
  endtask

  // R9 plus R4: pseudo-random complex taps and data
  task automatic t_random();
    logic [31:0] lf = 32'h1ACE_B00C;
    for (int i = 0; i < TAPS; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cr[i] = int'($signed(lf[15:0])) >>> 2;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ci[i] = int'($signed(lf[23:8])) >>> 2;
    end
    do_reset();
    tune_step = 6'd11;
    for (int n = 0; n < 200; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      in_valid = lf[5] | lf[9];
      in_re = $signed(lf[15:0]);
      in_im = $signed(lf[31:16]);
      cyc(); check_lanes("R9");
    end
  endtask

  initial begin
    clear_coefs();
    model_zero();
    @(negedge clk);
    do_reset();
    t_rotate(5);
    t_rotate(0);
    t_rotate(17);
    t_gaps();
    t_impulse();
    t_round();
    t_saturate();
    t_retune();
    t_random();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule